// File: doc/BRIEF.md
# DMA interrupt status aggregator

This block gathers interrupt events from the channels of a multi-channel DMA engine and turns them into three interrupt lines: one for completed transfers (terminal count), one for transfer errors, and one that is high when either of the other two is high. Each channel reports a terminal-count event or an error event as a one-cycle pulse that carries the channel index. The block records these pulses in two raw status vectors, one bit per channel for each kind of event.

Each interrupt kind has its own mask. The block does not store the masks as separate registers written by software. Instead it rebuilds them every cycle from two configuration vectors, with one interrupt-enable bit per channel for each kind. An event on a channel whose enable bit is clear is still recorded in the raw status, but it does not reach the interrupt line.

Software reads the raw vectors, the masked vectors and a combined masked vector through plain output ports. It acknowledges events with write-one-to-clear strobes, one strobe for each status kind, which share a data word. The channel count is a parameter: 8 for the full engine and 2 for the reduced variant.

Top module: `dma_irq_collector`

## Requirements
- R1: The terminal-count mask bit of channel i equals bit i of `tc_ie_cfg` as sampled at the previous clock edge.
- R2: The error mask bit of channel i equals bit i of `err_ie_cfg` as sampled at the previous clock edge.
- R3: A cycle with `tc_evt_valid` high sets bit `tc_evt_ch` of the raw terminal-count status at the next edge. A raw bit that is neither set nor cleared keeps its value.
- R4: A cycle with `err_evt_valid` high sets bit `err_evt_ch` of the raw error status at the next edge. A raw bit that is neither set nor cleared keeps its value.
- R5: A cycle with `tc_clr_we` high clears, at the next edge, every raw terminal-count bit whose position holds a 1 in `clr_data`. All other raw terminal-count bits are unchanged.
- R6: A cycle with `err_clr_we` high clears, at the next edge, every raw error bit whose position holds a 1 in `clr_data`. All other raw error bits are unchanged.
- R7: When an event and a clear target the same raw bit in the same cycle, the bit ends up set.
- R8: `irq_tc` is high exactly when (raw terminal-count AND terminal-count mask) was nonzero at the previous edge. `irq_err` follows the same rule for the error status and error mask.
- R9: `irq_any` equals `irq_tc` OR `irq_err` in every cycle.
- R10: `tc_msk_rd` equals raw terminal-count AND terminal-count mask, and `err_msk_rd` equals raw error AND error mask. `any_rd` equals `tc_msk_rd` OR `err_msk_rd`.
- R11: A cycle with `rst` high clears both raw vectors, both masks and all three interrupt lines at the next edge.
- R12: An event on a channel whose mask bit is 0 is recorded in the raw status but leaves the masked reads and the interrupt lines low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tc_evt_valid | input | 1 | Terminal-count event pulse |
| tc_evt_ch | input | CHW | Channel index of the terminal-count event |
| err_evt_valid | input | 1 | Error event pulse |
| err_evt_ch | input | CHW | Channel index of the error event |
| tc_ie_cfg | input | NUM_CH | Per-channel terminal-count interrupt enables |
| err_ie_cfg | input | NUM_CH | Per-channel error interrupt enables |
| tc_clr_we | input | 1 | Write-one-to-clear strobe for the raw terminal-count status |
| err_clr_we | input | 1 | Write-one-to-clear strobe for the raw error status |
| clr_data | input | NUM_CH | Clear data, where a 1 clears that channel's bit |
| tc_raw_rd | output | NUM_CH | Raw terminal-count status |
| err_raw_rd | output | NUM_CH | Raw error status |
| tc_msk_rd | output | NUM_CH | Masked terminal-count status |
| err_msk_rd | output | NUM_CH | Masked error status |
| any_rd | output | NUM_CH | Combined masked status |
| irq_tc | output | 1 | Terminal-count interrupt, registered |
| irq_err | output | 1 | Error interrupt, registered |
| irq_any | output | 1 | Combined interrupt, registered |

## Verification
A wrong raw bit appears on the raw read ports right after the edge that stored it. When that channel's mask bit is set, the same fault reaches the interrupt lines one edge later. A mask that is stuck or a cycle late shows on the masked reads in the cycle after the configuration changes, and on the interrupt lines in the cycle after that. The bench runs a reference model alongside the design and compares every read port and every interrupt line after each edge. It also covers set/clear collisions on both status kinds, events on masked channels, and a reset taken while status is pending.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  typedef enum logic {KIND_TC = 1'b0, KIND_ERR = 1'b1} irq_kind_e;

  function automatic logic any_bit(input logic [63:0] v);
    return |v;
  endfunction
endpackage

// File: rtl/dma_irq_mask_reg.sv
module dma_irq_mask_reg #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] ie_cfg,
  output logic [NUM_CH-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst) mask <= '0;
    else     mask <= ie_cfg;
  end

  // R1 / R2: mask tracks the enable bits one edge later
  a_r1_r2_mask_follow: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> mask == $past(ie_cfg));
endmodule

// File: rtl/dma_irq_status_bank.sv
module dma_irq_status_bank #(
  parameter int NUM_CH = 8,
  parameter int CHW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_v,
  input  logic [CHW-1:0]    set_ch,
  input  logic              clr_we,
  input  logic [NUM_CH-1:0] clr_data,
  output logic [NUM_CH-1:0] raw
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_bit
    logic hit;
    logic wipe;
    assign hit  = set_v && (set_ch == CHW'(i));
    assign wipe = clr_we && clr_data[i];

    always_ff @(posedge clk) begin
      if (rst)       raw[i] <= 1'b0;
      else if (hit)  raw[i] <= 1'b1;
      else if (wipe) raw[i] <= 1'b0;
    end

    // R7: a set beats a clear on the same bit
    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
      (set_v && set_ch == CHW'(i)) |=> raw[i]);
    // R5 / R6: a clear without a set empties the bit
    a_r5_r6_clear: assert property (@(posedge clk) disable iff (rst)
      (clr_we && clr_data[i] && !(set_v && set_ch == CHW'(i))) |=> !raw[i]);
    // R3 / R4: untouched bits hold
    a_r3_r4_hold: assert property (@(posedge clk) disable iff (rst)
      (!(clr_we && clr_data[i]) && !(set_v && set_ch == CHW'(i))) |=> $stable(raw[i]));
  end
endmodule

// File: rtl/dma_irq_out_stage.sv
module dma_irq_out_stage #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] tc_raw,
  input  logic [NUM_CH-1:0] tc_mask,
  input  logic [NUM_CH-1:0] err_raw,
  input  logic [NUM_CH-1:0] err_mask,
  output logic [NUM_CH-1:0] tc_msk_rd,
  output logic [NUM_CH-1:0] err_msk_rd,
  output logic [NUM_CH-1:0] any_rd,
  output logic              irq_tc,
  output logic              irq_err,
  output logic              irq_any
);
  always_comb begin
    tc_msk_rd  = tc_raw & tc_mask;
    err_msk_rd = err_raw & err_mask;
    any_rd     = tc_msk_rd | err_msk_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_tc  <= 1'b0;
      irq_err <= 1'b0;
      irq_any <= 1'b0;
    end else begin
      irq_tc  <= |tc_msk_rd;
      irq_err <= |err_msk_rd;
      irq_any <= |any_rd;
    end
  end

  // R8: lines follow the masked status of the previous edge
  a_r8_tc_line: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq_tc == $past(|(tc_raw & tc_mask)));
  a_r8_err_line: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq_err == $past(|(err_raw & err_mask)));
  // R9: combined line agrees with the two separate lines
  a_r9_any_line: assert property (@(posedge clk) disable iff (rst)
    irq_any == (irq_tc || irq_err));
endmodule

// File: rtl/dma_irq_collector.sv
module dma_irq_collector #(
  parameter int NUM_CH = 8,
  parameter int CHW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tc_evt_valid,
  input  logic [CHW-1:0]    tc_evt_ch,
  input  logic              err_evt_valid,
  input  logic [CHW-1:0]    err_evt_ch,
  input  logic [NUM_CH-1:0] tc_ie_cfg,
  input  logic [NUM_CH-1:0] err_ie_cfg,
  input  logic              tc_clr_we,
  input  logic              err_clr_we,
  input  logic [NUM_CH-1:0] clr_data,
  output logic [NUM_CH-1:0] tc_raw_rd,
  output logic [NUM_CH-1:0] err_raw_rd,
  output logic [NUM_CH-1:0] tc_msk_rd,
  output logic [NUM_CH-1:0] err_msk_rd,
  output logic [NUM_CH-1:0] any_rd,
  output logic              irq_tc,
  output logic              irq_err,
  output logic              irq_any
);
  import dma_irq_pkg::*;

  localparam int NKIND = 2;

  logic [NUM_CH-1:0] raw_v   [NKIND];
  logic [NUM_CH-1:0] mask_v  [NKIND];
  logic [NUM_CH-1:0] cfg_v   [NKIND];
  logic              setv_v  [NKIND];
  logic [CHW-1:0]    setch_v [NKIND];
  logic              clrwe_v [NKIND];

  always_comb begin
    cfg_v[KIND_TC]    = tc_ie_cfg;
    cfg_v[KIND_ERR]   = err_ie_cfg;
    setv_v[KIND_TC]   = tc_evt_valid;
    setv_v[KIND_ERR]  = err_evt_valid;
    setch_v[KIND_TC]  = tc_evt_ch;
    setch_v[KIND_ERR] = err_evt_ch;
    clrwe_v[KIND_TC]  = tc_clr_we;
    clrwe_v[KIND_ERR] = err_clr_we;
  end

  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    dma_irq_mask_reg #(.NUM_CH(NUM_CH)) u_mask (
      .clk    (clk),
      .rst    (rst),
      .ie_cfg (cfg_v[k]),
      .mask   (mask_v[k])
    );

    dma_irq_status_bank #(.NUM_CH(NUM_CH), .CHW(CHW)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .set_v    (setv_v[k]),
      .set_ch   (setch_v[k]),
      .clr_we   (clrwe_v[k]),
      .clr_data (clr_data),
      .raw      (raw_v[k])
    );
  end

  assign tc_raw_rd  = raw_v[KIND_TC];
  assign err_raw_rd = raw_v[KIND_ERR];

  dma_irq_out_stage #(.NUM_CH(NUM_CH)) u_out (
    .clk        (clk),
    .rst        (rst),
    .tc_raw     (raw_v[KIND_TC]),
    .tc_mask    (mask_v[KIND_TC]),
    .err_raw    (raw_v[KIND_ERR]),
    .err_mask   (mask_v[KIND_ERR]),
    .tc_msk_rd  (tc_msk_rd),
    .err_msk_rd (err_msk_rd),
    .any_rd     (any_rd),
    .irq_tc     (irq_tc),
    .irq_err    (irq_err),
    .irq_any    (irq_any)
  );

  // R11: a reset cycle leaves everything empty
  a_r11_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (tc_raw_rd == '0 && err_raw_rd == '0 && any_rd == '0 && !irq_any));
  // R12: a masked-off channel never drives the masked views
  a_r12_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    ((tc_msk_rd & ~mask_v[KIND_TC]) == '0) && ((err_msk_rd & ~mask_v[KIND_ERR]) == '0));
endmodule

// File: tb/sim_dma_irq_collector.sv
module sim_dma_irq_collector;
  localparam int N   = 8;
  localparam int CHW = 3;

  typedef struct packed {
    logic          tcv;
    logic [CHW-1:0] tcch;
    logic          erv;
    logic [CHW-1:0] erch;
    logic [N-1:0]  tcie;
    logic [N-1:0]  erie;
    logic          tcclr;
    logic          erclr;
    logic [N-1:0]  data;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 3'd2, 1'b0, 3'd0, 8'hFF, 8'hFF, 1'b0, 1'b0, 8'h00},
    '{1'b0, 3'd0, 1'b1, 3'd5, 8'hFF, 8'hFF, 1'b0, 1'b0, 8'h00},
    '{1'b1, 3'd7, 1'b1, 3'd0, 8'hFF, 8'hFF, 1'b0, 1'b0, 8'h00},
    '{1'b0, 3'd0, 1'b0, 3'd0, 8'hFF, 8'hFF, 1'b1, 1'b0, 8'h04},
    '{1'b0, 3'd0, 1'b0, 3'd0, 8'hFF, 8'hFF, 1'b0, 1'b1, 8'h21},
    '{1'b1, 3'd1, 1'b0, 3'd0, 8'h00, 8'hFF, 1'b0, 1'b0, 8'h00},
    '{1'b0, 3'd0, 1'b0, 3'd0, 8'hFF, 8'hFF, 1'b0, 1'b0, 8'h00},
    '{1'b1, 3'd3, 1'b0, 3'd0, 8'hFF, 8'hFF, 1'b1, 1'b0, 8'h08},
    '{1'b0, 3'd0, 1'b1, 3'd6, 8'h02, 8'h40, 1'b0, 1'b0, 8'h00},
    '{1'b0, 3'd0, 1'b0, 3'd0, 8'h02, 8'h40, 1'b1, 1'b1, 8'hFF},
    '{1'b0, 3'd0, 1'b0, 3'd0, 8'hFF, 8'hFF, 1'b0, 1'b0, 8'h00},
    '{1'b0, 3'd0, 1'b0, 3'd0, 8'hFF, 8'hFF, 1'b0, 1'b0, 8'h00}
  };

  logic clk = 1'b0;
  logic rst;
  logic tc_evt_valid, err_evt_valid, tc_clr_we, err_clr_we;
  logic [CHW-1:0] tc_evt_ch, err_evt_ch;
  logic [N-1:0] tc_ie_cfg, err_ie_cfg, clr_data;
  logic [N-1:0] tc_raw_rd, err_raw_rd, tc_msk_rd, err_msk_rd, any_rd;
  logic irq_tc, irq_err, irq_any;

  int checks = 0;
  int fails  = 0;

  logic [N-1:0] m_tc, m_er, m_tm, m_em;

  always #4 clk = ~clk;

  dma_irq_collector #(.NUM_CH(N)) u0 (
    .clk(clk), .rst(rst),
    .tc_evt_valid(tc_evt_valid), .tc_evt_ch(tc_evt_ch),
    .err_evt_valid(err_evt_valid), .err_evt_ch(err_evt_ch),
    .tc_ie_cfg(tc_ie_cfg), .err_ie_cfg(err_ie_cfg),
    .tc_clr_we(tc_clr_we), .err_clr_we(err_clr_we), .clr_data(clr_data),
    .tc_raw_rd(tc_raw_rd), .err_raw_rd(err_raw_rd),
    .tc_msk_rd(tc_msk_rd), .err_msk_rd(err_msk_rd), .any_rd(any_rd),
    .irq_tc(irq_tc), .irq_err(irq_err), .irq_any(irq_any)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    tc_evt_valid  = v.tcv;   tc_evt_ch  = v.tcch;
    err_evt_valid = v.erv;   err_evt_ch = v.erch;
    tc_ie_cfg     = v.tcie;  err_ie_cfg = v.erie;
    tc_clr_we     = v.tcclr; err_clr_we = v.erclr;
    clr_data      = v.data;
  endtask

  // one edge through design and model, then compare all ports
  task automatic step(input vec_t v);
    logic [N-1:0] tset, eset;
    logic exp_tc, exp_er;
    drive(v);
    exp_tc = |(m_tc & m_tm);
    exp_er = |(m_er & m_em);
    tset = v.tcv ? (N'(1) << v.tcch) : '0;
    eset = v.erv ? (N'(1) << v.erch) : '0;
    m_tc = ((v.tcclr ? (m_tc & ~v.data) : m_tc)) | tset;
    m_er = ((v.erclr ? (m_er & ~v.data) : m_er)) | eset;
    m_tm = v.tcie;
    m_em = v.erie;
    @(negedge clk);
    chk("R3/R5/R7 tc raw", 32'(tc_raw_rd), 32'(m_tc));
    chk("R4/R6 err raw", 32'(err_raw_rd), 32'(m_er));
    chk("R1/R10 tc masked", 32'(tc_msk_rd), 32'(m_tc & m_tm));
    chk("R2/R10 err masked", 32'(err_msk_rd), 32'(m_er & m_em));
    chk("R10 combined", 32'(any_rd), 32'((m_tc & m_tm) | (m_er & m_em)));
    chk("R8 irq_tc", 32'(irq_tc), 32'(exp_tc));
    chk("R8 irq_err", 32'(irq_err), 32'(exp_er));
    chk("R9 irq_any", 32'(irq_any), 32'(exp_tc | exp_er));
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    vec_t idle;
    idle = '{1'b0, 3'd0, 1'b0, 3'd0, 8'hFF, 8'hFF, 1'b0, 1'b0, 8'h00};
    rst = 1'b1;
    drive(idle);
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 reset tc raw", 32'(tc_raw_rd), 0);
    chk("R11 reset err raw", 32'(err_raw_rd), 0);
    chk("R11 reset masked", 32'(any_rd), 0);
    chk("R11 reset irq", 32'({irq_tc, irq_err, irq_any}), 0);
    rst = 1'b0;
    m_tc = '0; m_er = '0; m_tm = '0; m_em = '0;

    for (int i = 0; i < NV; i++) step(TBL[i]);

    // R12: event on masked-off channel is recorded raw only
    step('{1'b1, 3'd4, 1'b1, 3'd4, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00});
    chk("R12 raw recorded", 32'(tc_raw_rd[4] & err_raw_rd[4]), 1);
    step('{1'b0, 3'd0, 1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00});
    chk("R12 no irq", 32'(irq_any), 0);

    // R7: collision on the error side
    step('{1'b0, 3'd0, 1'b1, 3'd1, 8'hFF, 8'hFF, 1'b0, 1'b1, 8'h02});
    chk("R7 err set wins", 32'(err_raw_rd[1]), 1);
    step(idle);
    chk("R8 irq after collision", 32'(irq_err), 1);

    // R11: reset with pending status
    rst = 1'b1;
    drive(idle);
    @(negedge clk);
    chk("R11 mid reset raw", 32'({tc_raw_rd, err_raw_rd}), 0);
    chk("R11 mid reset irq", 32'({irq_tc, irq_err, irq_any}), 0);
    rst = 1'b0;
    m_tc = '0; m_er = '0; m_tm = '0; m_em = '0;
    step(idle);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule